// File: doc/BRIEF.md
# Manchester to Nibble Decoder

This block turns a 10 Mb/s Manchester-coded receive stream into NRZ data and delivers it four bits at a time. A recovered clock enable, `half_en`, marks each cycle in which `line_in` holds a new half-bit sample. The `carrier` flag is high while the squelch sees signal. Inside each bit cell the first half is the complement of the data bit and the second half is its true value. The decoder finds the half-bit phase from the transition that every valid cell has in its middle. After a short lock period it frames the bits into nibbles, least significant bit first, and raises `rx_dv` for the length of the frame.

Some preamble is lost while the decoder searches for lock. The rest of the preamble is delivered as nibbles of value 0x5. The start-of-frame delimiter arrives as a 0x5 nibble followed by a 0xD nibble. Payload nibbles follow on byte boundaries. The first cell with no mid-cell transition after data has started marks the end of the frame. The high start-of-idle pulse that closes a frame is never delivered as data.

The output stream has no back-pressure. A nibble is present for exactly one clock, while `nib_valid` is high. The consumer must take it in that cycle, because the line cannot be stalled. A new nibble comes at most once per eight `half_en` samples.

Top module: `manch_nibble_rx`

## Requirements
- R1: A cell whose two half samples differ carries the bit equal to its second half sample, so halves 0 then 1 decode to a 1 and halves 1 then 0 decode to a 0.
- R2: Bits are packed least significant bit first. `nib_valid` is a one-clock pulse that rises on the clock edge that samples the second half of a nibble's fourth bit, and `nib_data` is valid while it is high.
- R3: During acquisition, two cells in a row without a mid-cell transition shift the cell phase by one half sample. Lock is declared after LOCK_CELLS consecutive cells that have a transition.
- R4: After lock, the first nibble starts at the first decoded 1 bit, so preamble nibbles read 0x5. The first two consecutive 1 bits close a nibble, which then reads 0xD. Every later nibble holds one byte half, low half first.
- R5: With up to 12 preamble bits lost and with either starting half phase, at least six 0x5 nibbles are delivered before the 0xD nibble.
- R6: `rx_dv` stays low until the first whole nibble is assembled. It rises in the same cycle as that nibble's `nib_valid`, and `nib_valid` is never high while `rx_dv` is low.
- R7: Once data has started, a cell without a mid-cell transition ends the frame. `rx_dv` is low from the next clock, any partial nibble is dropped, and the trailing idle pulse yields no nibble.
- R8: While `carrier` is low the decoder returns to its search state. `rx_dv` is low from the next clock, any partial nibble is dropped, and line activity produces no nibble.
- R9: After reset, `nib_valid`, `rx_dv` and `nib_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_en | input | 1 | High for one clock when `line_in` holds a new half-bit sample |
| line_in | input | 1 | Sliced receive line level |
| carrier | input | 1 | Squelch output, high while signal is present |
| nib_data | output | 4 | Decoded nibble, first bit received in bit 0 |
| nib_valid | output | 1 | One-clock strobe marking a valid `nib_data` |
| rx_dv | output | 1 | Receive data valid for the frame |

## Verification
If the decoder locks on the wrong half phase, the first delivered nibble is not 0x5 or the frame ends at once with `rx_dv` falling. Either shows within one nibble time of lock. A wrong nibble frame makes the delimiter read something other than 0xD and shifts every payload byte, so the first payload byte exposes it. A fault in end-of-frame or carrier handling shows as an extra nibble from the idle pulse, a leftover partial nibble, or `rx_dv` still high one clock after the terminating cell or the carrier drop.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HUNT  = 3'd1,
    ST_ALIGN = 3'd2,
    ST_DATA  = 3'd3,
    ST_DRAIN = 3'd4
  } rx_state_t;
endpackage

// File: rtl/mcd_halfpair.sv
// Pairs half-bit samples into cells; a slip restarts the pairing on the current sample.
module mcd_halfpair (
  input  logic clk,
  input  logic rst_n,
  input  logic half_en,
  input  logic line_in,
  input  logic clear,
  input  logic slip,
  output logic cell_stb,
  output logic cell_ok,
  output logic cell_bit
);
  logic second_q;
  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      first_q  <= 1'b0;
    end else if (clear) begin
      second_q <= 1'b0;
    end else if (half_en) begin
      if (!second_q || slip) begin
        first_q  <= line_in;
        second_q <= 1'b1;
      end else begin
        second_q <= 1'b0;
      end
    end
  end

  assign cell_stb = half_en && second_q && !clear;
  assign cell_ok  = first_q ^ line_in;
  assign cell_bit = line_in;
endmodule

// File: rtl/mcd_ctrl.sv
// Acquisition, lock, alignment and end-of-frame control.
module mcd_ctrl
  import mcd_pkg::*;
#(
  parameter int LOCK_CELLS = 4,
  parameter int MISS_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier,
  input  logic cell_stb,
  input  logic cell_ok,
  input  logic cell_bit,
  output logic clear,
  output logic slip,
  output logic push,
  output logic flush
);
  localparam int GW = $clog2(LOCK_CELLS + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  rx_state_t   st_q;
  logic [GW-1:0] good_q;
  logic [MW-1:0] miss_q;

  logic acq, good, miss, end_evt;

  assign acq     = (st_q == ST_HUNT) || (st_q == ST_ALIGN);
  assign good    = cell_stb && cell_ok;
  assign miss    = cell_stb && !cell_ok;
  assign slip    = acq && miss && (miss_q == MW'(MISS_LIMIT - 1));
  assign push    = good && ((st_q == ST_DATA) || ((st_q == ST_ALIGN) && cell_bit));
  assign end_evt = (st_q == ST_DATA) && miss;
  assign flush   = !carrier || end_evt;
  assign clear   = !carrier || (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      good_q <= '0;
      miss_q <= '0;
    end else if (!carrier) begin
      st_q   <= ST_IDLE;
      good_q <= '0;
      miss_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_q   <= ST_HUNT;
          good_q <= '0;
          miss_q <= '0;
        end
        ST_HUNT: begin
          if (good) begin
            miss_q <= '0;
            if (good_q == GW'(LOCK_CELLS - 1)) begin
              st_q   <= ST_ALIGN;
              good_q <= '0;
            end else begin
              good_q <= good_q + GW'(1);
            end
          end else if (miss) begin
            good_q <= '0;
            miss_q <= slip ? '0 : miss_q + MW'(1);
          end
        end
        ST_ALIGN: begin
          if (good) begin
            miss_q <= '0;
            if (cell_bit) st_q <= ST_DATA;
          end else if (miss) begin
            if (slip) begin
              st_q   <= ST_HUNT;
              miss_q <= '0;
            end else begin
              miss_q <= miss_q + MW'(1);
            end
          end
        end
        ST_DATA: begin
          if (miss) st_q <= ST_DRAIN;
        end
        default: st_q <= st_q;
      endcase
    end
  end
endmodule

// File: rtl/mcd_pack.sv
// LSB-first nibble assembly with one-time re-anchoring on the first "11" pair.
module mcd_pack #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             bit_in,
  input  logic             flush,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_valid,
  output logic             rx_dv
);
  localparam int CW = (NIB_W > 1) ? $clog2(NIB_W) : 1;

  logic [NIB_W-1:0] sr_q;
  logic [CW-1:0]    cnt_q;
  logic             anchored_q;
  logic [NIB_W-1:0] nxt;
  logic             pair11, emit;

  assign nxt    = {bit_in, sr_q[NIB_W-1:1]};
  assign pair11 = bit_in && sr_q[NIB_W-1];
  assign emit   = push && ((cnt_q == CW'(NIB_W - 1)) || (!anchored_q && pair11));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      anchored_q <= 1'b0;
      nib_data   <= '0;
      nib_valid  <= 1'b0;
      rx_dv      <= 1'b0;
    end else begin
      nib_valid <= 1'b0;
      if (flush) begin
        sr_q       <= '0;
        cnt_q      <= '0;
        anchored_q <= 1'b0;
        rx_dv      <= 1'b0;
      end else if (push) begin
        sr_q <= nxt;
        if (emit) begin
          cnt_q     <= '0;
          nib_data  <= nxt;
          nib_valid <= 1'b1;
          rx_dv     <= 1'b1;
          if (pair11) anchored_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/manch_nibble_rx.sv
module manch_nibble_rx #(
  parameter int NIB_W      = 4,
  parameter int LOCK_CELLS = 4,
  parameter int MISS_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_en,
  input  logic             line_in,
  input  logic             carrier,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_valid,
  output logic             rx_dv
);
  logic cell_stb, cell_ok, cell_bit;
  logic clear, slip, push, flush;

  mcd_halfpair u_pair (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .line_in(line_in),
    .clear(clear), .slip(slip),
    .cell_stb(cell_stb), .cell_ok(cell_ok), .cell_bit(cell_bit)
  );

  mcd_ctrl #(.LOCK_CELLS(LOCK_CELLS), .MISS_LIMIT(MISS_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .carrier(carrier),
    .cell_stb(cell_stb), .cell_ok(cell_ok), .cell_bit(cell_bit),
    .clear(clear), .slip(slip), .push(push), .flush(flush)
  );

  mcd_pack #(.NIB_W(NIB_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .push(push), .bit_in(cell_bit), .flush(flush),
    .nib_data(nib_data), .nib_valid(nib_valid), .rx_dv(rx_dv)
  );
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
  input logic clk,
  input logic rst_n,
  input logic half_en,
  input logic carrier,
  input logic nib_valid,
  input logic rx_dv
);
  assert_valid_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid |-> rx_dv);

  assert_dv_rise_with_nibble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> nib_valid);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid |=> !nib_valid);

  assert_strobe_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nib_valid) |-> $past(half_en));

  assert_carrier_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier |=> (!rx_dv && !nib_valid));
endmodule

bind manch_nibble_rx mcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .carrier(carrier),
  .nib_valid(nib_valid), .rx_dv(rx_dv)
);

// File: tb/manch_nibble_rx_bench.sv
module manch_nibble_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_GAP   = 4;
  localparam int NV         = 6;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic [7:0] lost;
    logic       skew;
    logic [3:0] nbytes;
    logic [7:0] seed;
    logic [1:0] tail;
    logic       abrupt;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'd0,  1'b0, 4'd4, 8'h3C, 2'd0, 1'b0},
    '{8'd12, 1'b1, 4'd3, 8'hA7, 2'd0, 1'b0},
    '{8'd12, 1'b0, 4'd5, 8'h01, 2'd2, 1'b0},
    '{8'd6,  1'b1, 4'd2, 8'hF0, 2'd3, 1'b1},
    '{8'd10, 1'b0, 4'd6, 8'h5A, 2'd1, 1'b0},
    '{8'd4,  1'b1, 4'd1, 8'hFF, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_en = 1'b0;
  logic line_in = 1'b0;
  logic carrier = 1'b0;
  logic [3:0] nib_data;
  logic nib_valid;
  logic rx_dv;

  int checks = 0;
  int fails = 0;
  int rx_n = 0;
  int dv_early = 0;
  logic mon_en = 1'b0;
  logic [3:0] rx_buf [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;

  manch_nibble_rx u_manch_nibble_rx (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .line_in(line_in),
    .carrier(carrier), .nib_data(nib_data), .nib_valid(nib_valid), .rx_dv(rx_dv)
  );

  always @(negedge clk) begin
    if (mon_en) begin
      if (nib_valid) begin
        if (rx_n < 128) rx_buf[rx_n] = nib_data;
        rx_n = rx_n + 1;
      end else if (rx_dv && rx_n == 0) begin
        dv_early = dv_early + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_half(input logic v);
    @(negedge clk);
    line_in = v;
    half_en = 1'b1;
    @(negedge clk);
    half_en = 1'b0;
    repeat (HALF_GAP - 2) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    send_half(~b);
    send_half(b);
  endtask

  function automatic logic [7:0] pay_byte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 59);
  endfunction

  task automatic run_frame(input vec_t v);
    int k;
    int exp_n;
    logic [7:0] b;
    rx_n = 0;
    dv_early = 0;
    mon_en = 1'b1;
    @(negedge clk);
    carrier = 1'b1;
    repeat (2) @(negedge clk);
    if (v.skew) send_half(1'b1);
    for (int i = int'(v.lost); i < 56; i++) send_bit(i % 2 == 0);
    for (int i = 0; i < 8; i++) send_bit((i % 2 == 0) || (i == 7));
    for (int i = 0; i < int'(v.nbytes); i++) begin
      b = pay_byte(v.seed, i);
      for (int j = 0; j < 8; j++) send_bit(b[j]);
    end
    for (int j = 0; j < int'(v.tail); j++) send_bit(j[0]);
    if (v.abrupt) begin
      @(negedge clk);
      carrier = 1'b0;
      @(negedge clk);
      chk(rx_dv == 1'b0, "R8 dv after carrier drop", int'(rx_dv), 0);
    end else begin
      repeat (4) send_half(1'b1);
      @(negedge clk);
      chk(rx_dv == 1'b0, "R7 dv after idle pulse", int'(rx_dv), 0);
      carrier = 1'b0;
    end
    repeat (3) send_half(1'b0);
    repeat (4) @(negedge clk);
    mon_en = 1'b0;

    k = 0;
    while (k < rx_n && k < 128 && rx_buf[k] == 4'h5) k++;
    chk(k >= 6, "R3 R5 preamble nibbles", k, 6);
    chk(k < rx_n && rx_buf[k] == 4'hD, "R4 delimiter nibble",
        (k < rx_n) ? int'(rx_buf[k]) : -1, 13);
    for (int i = 0; i < int'(v.nbytes); i++) begin
      b = pay_byte(v.seed, i);
      chk((k + 2 + 2*i < rx_n) && {rx_buf[k+2+2*i], rx_buf[k+1+2*i]} == b,
          "R1 R2 payload byte",
          (k + 2 + 2*i < rx_n) ? int'({rx_buf[k+2+2*i], rx_buf[k+1+2*i]}) : -1, int'(b));
    end
    exp_n = k + 1 + 2 * int'(v.nbytes);
    chk(rx_n == exp_n, v.abrupt ? "R8 nibble count" : "R7 nibble count", rx_n, exp_n);
    chk(dv_early == 0, "R6 dv before first nibble", dv_early, 0);
  endtask

  initial begin
    int t = 0;
    while (t < WATCHDOG) begin
      @(posedge clk);
      t++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", t, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(nib_valid == 1'b0 && rx_dv == 1'b0, "R9 in reset", int'({nib_valid, rx_dv}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({nib_data, nib_valid, rx_dv} == 6'd0, "R9 after reset",
        int'({nib_data, nib_valid, rx_dv}), 0);

    for (int n = 0; n < NV; n++) run_frame(VECS[n]);

    // R8: line activity with carrier low produces nothing
    rx_n = 0;
    mon_en = 1'b1;
    for (int i = 0; i < 40; i++) send_half(i % 3 == 0);
    for (int i = 0; i < 30; i++) send_bit(i % 2 == 0);
    mon_en = 1'b0;
    chk(rx_n == 0, "R8 no nibble without carrier", rx_n, 0);
    chk(rx_dv == 1'b0, "R8 dv low without carrier", int'(rx_dv), 0);

    // R7: a frame whose data stops on a missing transition right after delimiter
    run_frame('{8'd0, 1'b1, 4'd0, 8'h00, 2'd2, 1'b0});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule